// File: doc/BRIEF.md
# Status Register Write Guard

This block owns the protection bits of a serial flash status register and rules on every attempt to overwrite them. The command decoder hands it a one-cycle request that marks the end of a received status-write data byte, along with that byte. The block also keeps the write-enable latch, which a separate one-cycle input sets. It reads the active-low write-protect pin through its own synchronizer and presents the full status byte. That byte merges the held bits with four read-only bits supplied by the surrounding device.

The held bits are the lock-down bit and two block-protect bits. When the synchronized protect pin is low and the lock-down bit is set, a status write is refused. When the pin is high, the lock-down bit plays no part in the decision. A write is also refused when the write-enable latch is clear. Every request produces exactly one outcome pulse, either accepted or refused. Every request also clears the write-enable latch.

Top module: `statusRegGuard`

## Requirements
- R1: After reset the status byte holds lock-down (bit 7) = 0, block-protect bits 3 and 2 = 1, write-enable (bit 1) = 0, and both outcome pulses are low.
- R2: Status layout: bit 7 lock-down, bit 3 upper block-protect, bit 2 lower block-protect, bit 1 write-enable latch. Bits 0, 4, 5 and 6 follow `roStatus[0]`, `roStatus[1]`, `roStatus[2]` and `roStatus[3]` combinationally.
- R3: A `setWel` pulse with no write request in the same cycle sets bit 1 at the next clock edge.
- R4: An accepted write copies data bits 7, 3 and 2 into the same status bits. The new value appears in the cycle where `wrAccept` is high. No other held bit changes.
- R5: A write request while the write-enable latch is clear is refused (`wrReject` pulse), and bits 7, 3 and 2 keep their values.
- R6: With the synchronized protect pin low and lock-down = 1, a request is refused and bits 7, 3 and 2 stay unchanged.
- R7: With the synchronized protect pin low and lock-down = 0, a request with the latch set is accepted.
- R8: With the synchronized protect pin high, a request with the latch set is accepted whatever the lock-down value.
- R9: Every request, accepted or refused, clears the write-enable latch. A `setWel` in the same cycle as a request has no effect.
- R10: The protect pin passes through two flops. A request on clock edge k is decided on the pin level captured at edge k-2. A pin change first captured at edge k-1 does not yet count.
- R11: Each request gives exactly one one-cycle pulse on `wrAccept` or `wrReject`, in the cycle after the request edge. No pulse appears without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrReq | input | 1 | One-cycle pulse: a status-write data byte is complete |
| wrData | input | 8 | Data byte of the status write |
| setWel | input | 1 | One-cycle pulse: set the write-enable latch |
| wpPinN | input | 1 | Write-protect pin, active low, asynchronous |
| roStatus | input | 4 | Read-only status bits from the device |
| statusOut | output | 8 | Current status byte |
| wrAccept | output | 1 | Pulse: the last request was applied |
| wrReject | output | 1 | Pulse: the last request was refused |

## Verification
A corrupted lock-down or block-protect bit shows on `statusOut` at once. It also flips the outcome of the next request under a low protect pin, one cycle after that request. A stuck write-enable latch is visible on bit 1 immediately and turns a later refusal into an acceptance. A synchronizer of the wrong depth shows up only when the pin moves one or two edges before a request. The bench therefore moves the pin at exactly those offsets and compares every cycle against a reference model.

// File: rtl/srgPkg.sv
package srgPkg;
  localparam int REG_W   = 8;
  localparam int RO_W    = 4;
  localparam int BPL_POS = 7;
  localparam int BP1_POS = 3;
  localparam int BP0_POS = 2;
  localparam int WEL_POS = 1;

  typedef struct packed {
    logic loadReg;
    logic setWel;
    logic clearWel;
    logic accept;
    logic reject;
  } srgStrobes_t;
endpackage

// File: rtl/srgSync.sv
module srgSync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= dIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], dIn};
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/srgControl.sv
module srgControl
  import srgPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrReq,
  input  logic        setWelReq,
  input  logic        wpPinN,
  input  logic        curBpl,
  input  logic        curWel,
  output srgStrobes_t strobes
);
  logic wpLevel;
  logic allowed;

  srgSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) wpSync_i (
    .clk (clk),
    .rstN(rstN),
    .dIn (wpPinN),
    .dOut(wpLevel)
  );

  // Pin high lifts the lock; pin low defers to the lock-down bit.
  always_comb begin
    allowed          = curWel && (wpLevel || !curBpl);
    strobes.loadReg  = wrReq && allowed;
    strobes.accept   = wrReq && allowed;
    strobes.reject   = wrReq && !allowed;
    strobes.clearWel = wrReq;
    strobes.setWel   = setWelReq && !wrReq;
  end
endmodule

// File: rtl/srgDatapath.sv
module srgDatapath
  import srgPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  srgStrobes_t       strobes,
  input  logic [REG_W-1:0]  wrData,
  input  logic [RO_W-1:0]   roStatus,
  output logic [REG_W-1:0]  statusOut,
  output logic              curBpl,
  output logic              curWel,
  output logic              wrAccept,
  output logic              wrReject
);
  logic bplQ, bp1Q, bp0Q, welQ;
  logic accQ, rejQ;
  logic unusedData;

  assign unusedData = ^{wrData[6:4], wrData[1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bplQ <= 1'b0;
      bp1Q <= 1'b1;
      bp0Q <= 1'b1;
    end else if (strobes.loadReg) begin
      bplQ <= wrData[BPL_POS];
      bp1Q <= wrData[BP1_POS];
      bp0Q <= wrData[BP0_POS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 welQ <= 1'b0;
    else if (strobes.clearWel) welQ <= 1'b0;
    else if (strobes.setWel)   welQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= 1'b0;
      rejQ <= 1'b0;
    end else begin
      accQ <= strobes.accept;
      rejQ <= strobes.reject;
    end
  end

  always_comb begin
    statusOut          = '0;
    statusOut[BPL_POS] = bplQ;
    statusOut[6:4]     = roStatus[3:1];
    statusOut[BP1_POS] = bp1Q;
    statusOut[BP0_POS] = bp0Q;
    statusOut[WEL_POS] = welQ;
    statusOut[0]       = roStatus[0];
  end

  assign curBpl   = bplQ;
  assign curWel   = welQ;
  assign wrAccept = accQ;
  assign wrReject = rejQ;
endmodule

// File: rtl/statusRegGuard.sv
module statusRegGuard
  import srgPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrReq,
  input  logic [REG_W-1:0] wrData,
  input  logic             setWel,
  input  logic             wpPinN,
  input  logic [RO_W-1:0]  roStatus,
  output logic [REG_W-1:0] statusOut,
  output logic             wrAccept,
  output logic             wrReject
);
  srgStrobes_t strobes;
  logic        curBpl;
  logic        curWel;

  srgControl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrReq    (wrReq),
    .setWelReq(setWel),
    .wpPinN   (wpPinN),
    .curBpl   (curBpl),
    .curWel   (curWel),
    .strobes  (strobes)
  );

  srgDatapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .roStatus (roStatus),
    .statusOut(statusOut),
    .curBpl   (curBpl),
    .curWel   (curWel),
    .wrAccept (wrAccept),
    .wrReject (wrReject)
  );
endmodule

// File: rtl/srgChecker.sv
module srgChecker (
  input logic       clk,
  input logic       rstN,
  input logic       wrReq,
  input logic [7:0] wrData,
  input logic       setWel,
  input logic [7:0] statusOut,
  input logic       wrAccept,
  input logic       wrReject
);
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> (wrAccept != wrReject));

  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rstN)
    !wrReq |=> (!wrAccept && !wrReject));

  p_load_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrAccept |-> (statusOut[7] == $past(wrData[7]) &&
                  statusOut[3] == $past(wrData[3]) &&
                  statusOut[2] == $past(wrData[2])));

  p_hold_on_reject_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrReject |-> $stable({statusOut[7], statusOut[3], statusOut[2]}));

  p_need_wel_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !statusOut[1]) |=> wrReject);

  p_wel_cleared_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> !statusOut[1]);

  p_wel_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (setWel && !wrReq) |=> statusOut[1]);
endmodule

bind statusRegGuard srgChecker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .wrReq    (wrReq),
  .wrData   (wrData),
  .setWel   (setWel),
  .statusOut(statusOut),
  .wrAccept (wrAccept),
  .wrReject (wrReject)
);

// File: tb/statusRegGuard_tb_top.sv
module statusRegGuard_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrReq = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       setWel = 1'b0;
  logic       wpPinN = 1'b1;
  logic [3:0] roStatus = 4'h0;
  logic [7:0] statusOut;
  logic       wrAccept, wrReject;

  int    nChecks = 0;
  int    nErrors = 0;
  bit    done = 0;
  string curTag = "R1";

  statusRegGuard dut_i (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrData(wrData), .setWel(setWel),
    .wpPinN(wpPinN), .roStatus(roStatus), .statusOut(statusOut),
    .wrAccept(wrAccept), .wrReject(wrReject)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic mBpl = 1'b0, mBp1 = 1'b1, mBp0 = 1'b1, mWel = 1'b0;
  logic mAcc = 1'b0, mRej = 1'b0;
  logic wpHist[$];

  always @(posedge clk) begin
    logic wpUse;
    if (!rstN) begin
      mBpl = 0; mBp1 = 1; mBp0 = 1; mWel = 0; mAcc = 0; mRej = 0;
      wpHist.delete();
    end else begin
      wpUse = (wpHist.size() >= 2) ? wpHist[wpHist.size()-2] : 1'b0;
      mAcc = 0; mRej = 0;
      if (wrReq) begin
        if (mWel && (wpUse || !mBpl)) begin
          mAcc = 1; mBpl = wrData[7]; mBp1 = wrData[3]; mBp0 = wrData[2];
        end else begin
          mRej = 1;
        end
        mWel = 0;
      end else if (setWel) begin
        mWel = 1;
      end
      wpHist.push_back(wpPinN);
      if (wpHist.size() > 4) void'(wpHist.pop_front());
    end
  end

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual {status,acc,rej}=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every cycle, a quarter period after the rising edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (!done)
      check(curTag, {statusOut, wrAccept, wrReject},
            {mBpl, roStatus[3:1], mBp1, mBp0, mWel, roStatus[0], mAcc, mRej});
  end

  task automatic drive(logic req, logic [7:0] data, logic sw, logic wp);
    @(negedge clk);
    wrReq = req; wrData = data; setWel = sw; wpPinN = wp;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 1'b0, wpPinN);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: directed reset value, read-only bits all zero
    check("R1", {statusOut, wrAccept, wrReject}, {8'b0000_1100, 2'b00});
    rstN = 1'b1;
    idle(3);

    curTag = "R2";
    for (int v = 0; v < 16; v += 5) begin
      @(negedge clk); roStatus = v[3:0];
    end
    idle(1);

    curTag = "R3";
    drive(0, 8'h00, 1, 1); idle(1);

    curTag = "R4";
    drive(1, 8'h00, 0, 1); idle(1);

    curTag = "R5";
    drive(1, 8'h8C, 0, 1); idle(1);

    curTag = "R8";
    drive(0, 8'h00, 1, 1); drive(1, 8'h84, 0, 1); idle(1);
    drive(0, 8'h00, 1, 1); drive(1, 8'h88, 0, 1); idle(1);

    curTag = "R6";
    drive(0, 8'h00, 0, 0); idle(3);
    drive(0, 8'h00, 1, 0); drive(1, 8'h00, 0, 0); idle(1);

    curTag = "R9";
    drive(0, 8'h00, 1, 0); idle(1);
    drive(1, 8'h7F, 0, 0); idle(2);

    curTag = "R10";
    // pin raised one edge before the request: still locked
    drive(0, 8'h00, 1, 1); drive(1, 8'h04, 0, 1); idle(3);
    // pin high long enough: accepted, lock stays set
    drive(0, 8'h00, 1, 1); drive(1, 8'h8C, 0, 1); idle(3);
    // pin lowered one edge before the request: still unlocked
    drive(0, 8'h00, 1, 0); drive(1, 8'h08, 0, 0); idle(3);

    curTag = "R7";
    drive(0, 8'h00, 1, 0); drive(1, 8'h84, 0, 0); idle(2);

    curTag = "R9";
    drive(0, 8'h00, 0, 1); idle(3);
    drive(0, 8'h00, 1, 1); drive(1, 8'h00, 1, 1); idle(1);
    drive(1, 8'h8C, 0, 1); idle(2);

    curTag = "R11";
    idle(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule